// File: doc/BRIEF.md
# Segmented Speculative Adder with Selectable Exactness

This block adds two unsigned operands of `WIDTH` bits. Its carry chain is broken into segments of `SEG` bits. A row of overlapping sub-adders, each `2*SEG` bits wide, replaces the full chain. Sub-adder `i` covers segments `i` and `i+1` and has no carry input. For every sub-adder except the lowest, the lower half exists only to guess the carry into its upper half. That guess is the carry generated by the segment below, taken in isolation. The longest carry path is therefore `2*SEG` bits, whatever `WIDTH` is.

The guess is wrong for segment `j` (with `j >= 2`) when segment `j-1` propagates a carry that reaches it from further down. The block detects the first-order case of this directly: segment `j-1` sums to all ones, and segment `j-2` generates a carry. The result is reported on `err_flag`.

In approximate mode the speculative result leaves on the next clock edge. In exact mode the block corrects the result in place. It adds one to one mispredicted segment per cycle, lowest first. A segment that wraps passes its carry on to the next segment, or to `carry_out` for the top segment. `WIDTH` must be a multiple of `SEG` with `WIDTH/SEG >= 3`.

Top module: `spec_seg_adder`

## Requirements
- R1: In both modes, the low `2*SEG` bits of `sum` always equal the low `2*SEG` bits of `op_a + op_b`.
- R2: In approximate mode (`exact_mode` = 0), segment `j >= 2` of `sum` is bits `[2*SEG-1:SEG]` of `op_a[j*SEG-SEG +: 2*SEG] + op_b[j*SEG-SEG +: 2*SEG]`. `carry_out` is the carry out of that same addition for the top segment.
- R3: `err_flag` is set exactly when, for some `j >= 2`, `op_a` and `op_b` segment `j-1` sum to all ones and segment `j-2` sums to at least `2**SEG`. In approximate mode, `{carry_out,sum}` differs from the exact sum if and only if `err_flag` is set.
- R4: An operation is accepted on a rising edge with `in_valid` = 1 while the block is idle. In approximate mode, `out_valid` and the result appear on that same edge.
- R5: In exact mode (`exact_mode` = 1), `{carry_out,sum}` equals `op_a + op_b` exactly.
- R6: In exact mode, the result is due `n` edges after the accepting edge. `n` is the number of segments `j >= 2` whose true carry-in differs from the carry generated by segment `j-1` alone. `err_flag` is 1 if and only if `n > 0`.
- R7: While a correction is in progress, `in_valid` is ignored and `out_valid` stays 0.
- R8: `out_valid` is a one-cycle pulse for each accepted operation. After a synchronous reset, `out_valid`, `sum`, `carry_out` and `err_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Start an operation (taken only when idle) |
| exact_mode | input | 1 | 1 = exact result, 0 = speculative result |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| sum | output | WIDTH | Registered sum |
| carry_out | output | 1 | Registered carry out |
| err_flag | output | 1 | Speculation fault detected for this operation |
| out_valid | output | 1 | Result strobe, one cycle |

## Verification
Approximate results, and exact results with no misprediction, are due on the edge that accepts the operation. An exact result with `n` mispredicted segments is due `n` edges later. The bench works out `n` from its own per-segment carry model. It then counts falling edges after driving `in_valid` and requires the strobe to arrive after exactly `1+n` of them, checking the outputs at that falling edge and again one cycle later for the pulse. To show that inputs are ignored during a correction, the bench drives a different operand pair during the first busy cycle and expects the original result.

// File: rtl/asa_pkg.sv
package asa_pkg;
  typedef enum logic {ST_IDLE, ST_FIX} fix_state_e;
endpackage

// File: rtl/asa_subadder.sv
module asa_subadder #(
  parameter int SEG = 4
) (
  input  logic [SEG-1:0] a_lo,
  input  logic [SEG-1:0] b_lo,
  input  logic [SEG-1:0] a_hi,
  input  logic [SEG-1:0] b_hi,
  output logic [SEG-1:0] sum_lo,
  output logic [SEG-1:0] sum_hi,
  output logic           lo_prop,
  output logic           lo_gen,
  output logic           cout
);
  logic [SEG:0] lo_full;
  logic [SEG:0] hi_full;

  always_comb begin
    lo_full = {1'b0, a_lo} + {1'b0, b_lo};
    hi_full = {1'b0, a_hi} + {1'b0, b_hi} + {{SEG{1'b0}}, lo_full[SEG]};
  end

  assign sum_lo  = lo_full[SEG-1:0];
  assign sum_hi  = hi_full[SEG-1:0];
  assign lo_prop = &lo_full[SEG-1:0];
  assign lo_gen  = lo_full[SEG];
  assign cout    = hi_full[SEG];
endmodule

// File: rtl/asa_spec_core.sv
module asa_spec_core #(
  parameter int WIDTH = 16,
  parameter int SEG   = 4
) (
  input  logic [WIDTH-1:0]       op_a,
  input  logic [WIDTH-1:0]       op_b,
  output logic [WIDTH-1:0]       spec_sum,
  output logic                   spec_cout,
  output logic [WIDTH/SEG-1:0]   miss_mask
);
  localparam int SEGS = WIDTH / SEG;
  localparam int SUBS = SEGS - 1;

  logic [SEG-1:0] lo_s [SUBS];
  logic [SEG-1:0] hi_s [SUBS];
  logic [SUBS-1:0] prop;
  logic [SUBS-1:0] gen;
  logic [SUBS-1:0] co;

  genvar i;
  generate
    for (i = 0; i < SUBS; i++) begin : g_sub
      asa_subadder #(.SEG(SEG)) u_sub (
        .a_lo   (op_a[i*SEG +: SEG]),
        .b_lo   (op_b[i*SEG +: SEG]),
        .a_hi   (op_a[(i+1)*SEG +: SEG]),
        .b_hi   (op_b[(i+1)*SEG +: SEG]),
        .sum_lo (lo_s[i]),
        .sum_hi (hi_s[i]),
        .lo_prop(prop[i]),
        .lo_gen (gen[i]),
        .cout   (co[i])
      );
      assign spec_sum[(i+1)*SEG +: SEG] = hi_s[i];
    end
    for (i = 2; i < SEGS; i++) begin : g_miss
      assign miss_mask[i] = prop[i-1] & gen[i-2];
    end
  endgenerate

  assign spec_sum[SEG-1:0] = lo_s[0];
  assign miss_mask[1:0]    = 2'b00;
  assign spec_cout         = co[SUBS-1];
endmodule

// File: rtl/asa_fix_unit.sv
module asa_fix_unit #(
  parameter int WIDTH = 16,
  parameter int SEG   = 4
) (
  input  logic [WIDTH-1:0]     sum_in,
  input  logic [WIDTH/SEG-1:0] pend_in,
  output logic [WIDTH/SEG-1:0] pend_out,
  output logic [WIDTH-1:0]     sum_out,
  output logic                 cout_set
);
  localparam int SEGS = WIDTH / SEG;

  logic [SEGS-1:0] pick;
  logic [SEGS-1:0] wrap;

  assign pick = pend_in & (~pend_in + {{(SEGS-1){1'b0}}, 1'b1});

  genvar j;
  generate
    for (j = 0; j < SEGS; j++) begin : g_seg
      logic [SEG-1:0] seg_in;
      assign seg_in = sum_in[j*SEG +: SEG];
      assign sum_out[j*SEG +: SEG] = pick[j] ? seg_in + {{(SEG-1){1'b0}}, 1'b1} : seg_in;
      assign wrap[j] = pick[j] & (&seg_in);
    end
  endgenerate

  assign pend_out = (pend_in & ~pick) | {wrap[SEGS-2:0], 1'b0};
  assign cout_set = wrap[SEGS-1];
endmodule

// File: rtl/spec_seg_adder.sv
module spec_seg_adder #(
  parameter int WIDTH = 16,
  parameter int SEG   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             exact_mode,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             err_flag,
  output logic             out_valid
);
  import asa_pkg::*;
  localparam int SEGS = WIDTH / SEG;

  logic [WIDTH-1:0] spec_sum;
  logic             spec_cout;
  logic [SEGS-1:0]  miss_mask;
  logic [WIDTH-1:0] fix_sum;
  logic [SEGS-1:0]  fix_pend;
  logic             fix_cout;

  fix_state_e       state_q;
  logic [WIDTH-1:0] sum_q;
  logic             cout_q;
  logic             err_q;
  logic             valid_q;
  logic [SEGS-1:0]  pend_q;
  logic             busy;

  asa_spec_core #(.WIDTH(WIDTH), .SEG(SEG)) u_core (
    .op_a     (op_a),
    .op_b     (op_b),
    .spec_sum (spec_sum),
    .spec_cout(spec_cout),
    .miss_mask(miss_mask)
  );

  asa_fix_unit #(.WIDTH(WIDTH), .SEG(SEG)) u_fix (
    .sum_in  (sum_q),
    .pend_in (pend_q),
    .pend_out(fix_pend),
    .sum_out (fix_sum),
    .cout_set(fix_cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sum_q   <= '0;
      cout_q  <= 1'b0;
      err_q   <= 1'b0;
      valid_q <= 1'b0;
      pend_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            sum_q  <= spec_sum;
            cout_q <= spec_cout;
            err_q  <= |miss_mask;
            if (exact_mode && (|miss_mask)) begin
              pend_q  <= miss_mask;
              state_q <= ST_FIX;
            end else begin
              valid_q <= 1'b1;
            end
          end
        end
        default: begin
          sum_q  <= fix_sum;
          pend_q <= fix_pend;
          if (fix_cout) cout_q <= 1'b1;
          if (fix_pend == '0) begin
            state_q <= ST_IDLE;
            valid_q <= 1'b1;
          end
        end
      endcase
    end
  end

  assign busy      = (state_q == ST_FIX);
  assign sum       = sum_q;
  assign carry_out = cout_q;
  assign err_flag  = err_q;
  assign out_valid = valid_q;
endmodule

// File: rtl/asa_checker.sv
module asa_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             exact_mode,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [WIDTH-1:0] sum,
  input logic             carry_out,
  input logic             err_flag,
  input logic             out_valid,
  input logic             busy
);
  logic [WIDTH-1:0] cap_a;
  logic [WIDTH-1:0] cap_b;
  logic             cap_mode;
  logic [7:0]       fix_cnt;
  logic             accept;
  logic [WIDTH:0]   exact_val;

  assign accept    = in_valid && !busy;
  assign exact_val = {1'b0, cap_a} + {1'b0, cap_b};

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_a    <= '0;
      cap_b    <= '0;
      cap_mode <= 1'b0;
      fix_cnt  <= '0;
    end else if (accept) begin
      cap_a    <= op_a;
      cap_b    <= op_b;
      cap_mode <= exact_mode;
      fix_cnt  <= '0;
    end else if (busy) begin
      fix_cnt  <= fix_cnt + 8'd1;
    end
  end

  a_r5_exact_sum: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cap_mode) |-> ({carry_out, sum} == exact_val));

  a_r3_clean_unless_flagged: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !cap_mode && !err_flag) |-> ({carry_out, sum} == exact_val));

  a_r4_approx_next_edge: assert property (@(posedge clk) disable iff (rst)
    (accept && !exact_mode) |=> (out_valid && !busy));

  a_r7_quiet_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !out_valid);

  a_r6_flag_vs_latency: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cap_mode) |-> (err_flag == (fix_cnt != 8'd0)));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !accept) |=> !out_valid);
endmodule

bind spec_seg_adder asa_checker #(.WIDTH(WIDTH)) u_asa_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .exact_mode(exact_mode),
  .op_a      (op_a),
  .op_b      (op_b),
  .sum       (sum),
  .carry_out (carry_out),
  .err_flag  (err_flag),
  .out_valid (out_valid),
  .busy      (busy)
);

// File: tb/tb_spec_seg_adder.sv
module tb_spec_seg_adder;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int K = 4;
  localparam int M = W / K;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         exact_mode = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [W-1:0] sum;
  logic         carry_out;
  logic         err_flag;
  logic         out_valid;

  int n_tests = 0;
  int n_fail  = 0;
  int unsigned seed_init;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_seg_adder #(.WIDTH(W), .SEG(K)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .exact_mode(exact_mode),
    .op_a(op_a), .op_b(op_b), .sum(sum), .carry_out(carry_out),
    .err_flag(err_flag), .out_valid(out_valid)
  );

  function automatic logic [W:0] f_spec(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] r;
    logic [2*K:0] t;
    r = '0;
    t = {1'b0, a[2*K-1:0]} + {1'b0, b[2*K-1:0]};
    r[2*K-1:0] = t[2*K-1:0];
    r[W] = t[2*K];
    for (int j = 2; j < M; j++) begin
      t = {1'b0, a[(j-1)*K +: 2*K]} + {1'b0, b[(j-1)*K +: 2*K]};
      r[j*K +: K] = t[2*K-1:K];
      r[W] = t[2*K];
    end
    return r;
  endfunction

  function automatic int f_nmiss(input logic [W-1:0] a, input logic [W-1:0] b);
    int n;
    logic c;
    logic [K:0] s;
    logic [K:0] g;
    n = 0;
    c = 1'b0;
    for (int j = 0; j < M; j++) begin
      if (j >= 2) begin
        g = {1'b0, a[(j-1)*K +: K]} + {1'b0, b[(j-1)*K +: K]};
        if (c != g[K]) n++;
      end
      s = {1'b0, a[j*K +: K]} + {1'b0, b[j*K +: K]} + {{K{1'b0}}, c};
      c = s[K];
    end
    return n;
  endfunction

  function automatic logic f_flag(input logic [W-1:0] a, input logic [W-1:0] b);
    logic f;
    logic [K:0] p;
    logic [K:0] g;
    f = 1'b0;
    for (int j = 2; j < M; j++) begin
      p = {1'b0, a[(j-1)*K +: K]} + {1'b0, b[(j-1)*K +: K]};
      g = {1'b0, a[(j-2)*K +: K]} + {1'b0, b[(j-2)*K +: K]};
      if ((p == {1'b0, {K{1'b1}}}) && g[K]) f = 1'b1;
    end
    return f;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic mode);
    logic [W:0] exact;
    logic [W:0] spec;
    logic [W:0] want;
    logic       flag;
    int         n;
    int         lat;
    int         cyc;
    logic       got;
    exact = {1'b0, a} + {1'b0, b};
    spec  = f_spec(a, b);
    flag  = f_flag(a, b);
    n     = f_nmiss(a, b);
    lat   = (mode && n > 0) ? 1 + n : 1;
    want  = mode ? exact : spec;
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; exact_mode = mode;
    cyc = 0; got = 1'b0;
    while (!got && cyc < 40) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1 && lat > 1) begin
        // R7: new operands during the correction must be ignored
        op_a = ~a; op_b = b ^ 16'h5A5A; in_valid = 1'b1; exact_mode = ~mode;
      end else begin
        in_valid = 1'b0;
      end
      if (out_valid) got = 1'b1;
    end
    in_valid = 1'b0;
    chk(cyc == lat, mode ? "R6 latency" : "R4 latency", 64'(cyc), 64'(lat));
    chk({carry_out, sum} == want, mode ? "R5 exact sum" : "R2 speculative sum",
        64'({carry_out, sum}), 64'(want));
    chk(sum[2*K-1:0] == exact[2*K-1:0], "R1 low segments", 64'(sum[2*K-1:0]), 64'(exact[2*K-1:0]));
    if (mode) chk(err_flag == (n > 0), "R6 err_flag", 64'(err_flag), 64'(n > 0));
    else begin
      chk(err_flag == flag, "R3 err_flag formula", 64'(err_flag), 64'(flag));
      chk(err_flag == (spec != exact), "R3 flag marks wrong result", 64'(err_flag), 64'(spec != exact));
    end
    @(negedge clk);
    chk(out_valid == 1'b0, (lat > 1) ? "R7 busy input ignored" : "R8 single pulse",
        64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    seed_init = $urandom(32'h00C0FFEE);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(out_valid == 1'b0, "R8 reset valid", 64'(out_valid), 64'd0);
    chk({err_flag, carry_out, sum} == '0, "R8 reset outputs", 64'({err_flag, carry_out, sum}), 64'd0);

    // directed corners
    for (int m = 0; m < 2; m++) begin
      run_op(16'h0000, 16'h0000, m[0]);
      run_op(16'hFFFF, 16'hFFFF, m[0]);
      run_op(16'hFFFF, 16'h0001, m[0]);
      run_op(16'h0F08, 16'h0008, m[0]);
      run_op(16'h0FF8, 16'h0008, m[0]);
      run_op(16'hFFF8, 16'h0008, m[0]);
      run_op(16'h7F80, 16'h0080, m[0]);
      run_op(16'hF0F8, 16'h0F08, m[0]);
    end

    // constrained random: plain and propagate-heavy operands
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] a;
      logic [W-1:0] b;
      a = W'($urandom);
      if (i % 2 == 0) b = W'($urandom);
      else b = ~a ^ W'(1 << ($urandom % W)) ^ W'(($urandom % 2) << ($urandom % W));
      run_op(a, b, ($urandom % 2) == 1);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule